// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of a 16-bit interval timer that sits behind a small word-addressed register port. An up counter advances on ticks taken from one of two source enables. The selected source first passes through a power-of-two prescaler. Two compare registers watch the counter. A match on either one sets a sticky event flag. The second comparator can also wrap the counter back to zero, which turns the channel into a periodic interval source, and it can drive a level interrupt request.

Software configures the channel with one write to the setup word. That first write fixes the mode, clock source, prescale and stop behaviour. It also sets a status bit that reads back as one, so software can see that the configuration was taken. After that, only the run-enable bit and the write-one-to-clear event bits respond to writes. Software can rewrite the compare values and the counter at any time to set the next interval.

The design runs in a single clock domain. The fast and slow timebases reach it as one-cycle enable pulses on `fast_tick_i` and `slow_tick_i`.

Top module: `gpt_channel`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The word addresses are 0 = compare A, 1 = compare B, 2 = counter and 3 = setup. The setup word is laid out as follows: bit 15 is run enable, bit 14 is the compare-B event, bit 13 is the compare-A event, bit 12 is the lock status, bit 11 is stop enable, bits 9:8 are the compare-B mode, bit 4 is the source select and bits 3:0 are the prescale. Bits 10 and 7:5 always read zero. A read returns data on the cycle after `bus_rd_i`.
- R3: The first write to setup loads bits 11:0 and sets the lock bit. Every later write leaves bits 11:0 unchanged, while bit 15 still takes the written value.
- R4: With prescale P, the counter advances once for every 2^P enables of the selected source.
- R5: When the source select is 1, the counter uses `fast_tick_i`. When it is 0, the counter uses `slow_tick_i`.
- R6: Compare-B mode 00 disables the comparator, 01 matches on equality, and 10 and 11 match on greater-or-equal. On a counter tick that matches, the counter loads zero, so the period is (compare B + 1)·2^P source enables.
- R7: A counter tick on which the counter equals compare A sets the compare-A event.
- R8: Each event bit is sticky and is cleared by writing one to it in setup. A match in the same cycle as the clear wins, and the bit stays set.
- R9: `irq_o` is high exactly while the compare-B event is set and mode is 11. It is registered, it stays high until the event is cleared, and it stays low in the other modes.
- R10: A write to the counter loads the written value. While run enable is 0, the counter holds its value.
- R11: While stop enable is 1 and `halt_i` is high, the counter and prescaler freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick_i | input | 1 | Enable pulse of the fast timebase |
| slow_tick_i | input | 1 | Enable pulse of the slow timebase |
| halt_i | input | 1 | Freeze request, honoured when stop enable is set |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Level interrupt request from compare B |

## Verification
A compare-B match and a software write-one-to-clear of the compare-B event can land in the same cycle. The bench forces this collision by setting compare B to zero in greater-or-equal mode with no prescale. Every enabled cycle then matches, so any clear write is certain to meet a match. It then reads setup and checks the interrupt to confirm that the event bit and `irq_o` stayed set. The same clear with a long interval is checked to drop both, which shows that the clear path itself works.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int DW     = 16;               // register and counter width
  localparam int PS_W   = 4;                // prescale field width
  localparam int PRE_W  = (1 << PS_W) - 1;  // prescaler counter width
  localparam int AW     = 2;

  typedef enum logic [AW-1:0] {
    A_CMPA  = 2'd0,
    A_CMPB  = 2'd1,
    A_COUNT = 2'd2,
    A_SETUP = 2'd3
  } gpt_addr_e;

  // setup word bit positions
  localparam int B_RUN    = 15;
  localparam int B_EVB    = 14;
  localparam int B_EVA    = 13;
  localparam int B_LOCK   = 12;
  localparam int B_STOP   = 11;
  localparam int B_MODE_H = 9;
  localparam int B_MODE_L = 8;
  localparam int B_SRC    = 4;

  localparam logic [11:0] CFG_MASK = 12'hB1F;

  typedef enum logic [1:0] {
    M_OFF   = 2'b00,
    M_EQ    = 2'b01,
    M_GE    = 2'b10,
    M_GEIRQ = 2'b11
  } gpt_mode_e;

  typedef struct packed {
    logic            stop_en;
    gpt_mode_e       mode;
    logic            src_fast;
    logic [PS_W-1:0] prescale;
  } gpt_cfg_t;

  function automatic gpt_cfg_t cfg_decode(input logic [11:0] raw);
    gpt_cfg_t c;
    c.stop_en  = raw[B_STOP];
    c.mode     = gpt_mode_e'(raw[B_MODE_H:B_MODE_L]);
    c.src_fast = raw[B_SRC];
    c.prescale = raw[PS_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
  import gpt_pkg::*;
#(
  parameter int PSW  = PS_W,
  parameter int PREW = (1 << PSW) - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           src_fast,
  input  logic           fast_tick_i,
  input  logic           slow_tick_i,
  input  logic [PSW-1:0] prescale,
  output logic           tick
);

  logic [PREW-1:0] pre_q;
  logic [PREW-1:0] mask;
  logic            src_en;
  logic            step;

  always_comb begin
    src_en = src_fast ? fast_tick_i : slow_tick_i;
    step   = src_en && run;
    mask   = ~({PREW{1'b1}} << prescale);
    tick   = step && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (!run) begin
      pre_q <= pre_q;
    end else if (step) begin
      pre_q <= pre_q + PREW'(1);
    end
  end

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int W = DW
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      cnt_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  gpt_mode_e mode,
  output logic [W-1:0] cnt,
  output logic      hit_a,
  output logic      hit_b
);

  logic [W-1:0] cnt_q;
  logic         match_b;

  always_comb begin
    unique case (mode)
      M_OFF:   match_b = 1'b0;
      M_EQ:    match_b = (cnt_q == cmp_b);
      default: match_b = (cnt_q >= cmp_b);
    endcase
    hit_b = tick && match_b;
    hit_a = tick && (cnt_q == cmp_a);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata;
    end else if (tick) begin
      cnt_q <= match_b ? '0 : cnt_q + W'(1);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt,
  input  logic          hit_a,
  input  logic          hit_b,
  output logic [DW-1:0] cmp_a,
  output logic [DW-1:0] cmp_b,
  output gpt_cfg_t      cfg,
  output logic          run_en,
  output logic          locked,
  output logic          ev_b,
  output logic          clr_b,
  output logic [DW-1:0] rdata,
  output logic          irq
);

  logic [DW-1:0] cmp_a_q, cmp_b_q, rdata_q;
  logic [11:0]   cfg_raw_q;
  logic          lock_q, run_q, ev_a_q, ev_b_q, irq_q;
  logic          wr_setup, clr_a;
  logic          ev_a_n, ev_b_n;
  logic [DW-1:0] setup_word;

  always_comb begin
    wr_setup   = wr && (gpt_addr_e'(addr) == A_SETUP);
    clr_a      = wr_setup && wdata[B_EVA];
    clr_b      = wr_setup && wdata[B_EVB];
    ev_a_n     = hit_a ? 1'b1 : (clr_a ? 1'b0 : ev_a_q);
    ev_b_n     = hit_b ? 1'b1 : (clr_b ? 1'b0 : ev_b_q);
    cfg        = cfg_decode(cfg_raw_q);
    setup_word = {run_q, ev_b_q, ev_a_q, lock_q, cfg_raw_q & CFG_MASK};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_a_q   <= '0;
      cmp_b_q   <= '0;
      cfg_raw_q <= '0;
      lock_q    <= 1'b0;
      run_q     <= 1'b0;
      ev_a_q    <= 1'b0;
      ev_b_q    <= 1'b0;
      irq_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (wr && gpt_addr_e'(addr) == A_CMPA) cmp_a_q <= wdata;
      if (wr && gpt_addr_e'(addr) == A_CMPB) cmp_b_q <= wdata;
      if (wr_setup) begin
        run_q <= wdata[B_RUN];
        if (!lock_q) begin
          cfg_raw_q <= wdata[11:0];
          lock_q    <= 1'b1;
        end
      end
      ev_a_q <= ev_a_n;
      ev_b_q <= ev_b_n;
      irq_q  <= ev_b_n && (cfg.mode == M_GEIRQ);
      if (rd) begin
        unique case (gpt_addr_e'(addr))
          A_CMPA:  rdata_q <= cmp_a_q;
          A_CMPB:  rdata_q <= cmp_b_q;
          A_COUNT: rdata_q <= cnt;
          default: rdata_q <= setup_word;
        endcase
      end
    end
  end

  assign cmp_a  = cmp_a_q;
  assign cmp_b  = cmp_b_q;
  assign run_en = run_q;
  assign locked = lock_q;
  assign ev_b   = ev_b_q;
  assign rdata  = rdata_q;
  assign irq    = irq_q;

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          fast_tick_i,
  input  logic          slow_tick_i,
  input  logic          halt_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [15:0]   bus_wdata_i,
  output logic [15:0]   bus_rdata_o,
  output logic          irq_o
);

  logic [DW-1:0] cmp_a, cmp_b, cnt;
  gpt_cfg_t      cfg;
  logic          run_en, locked, ev_b, clr_b;
  logic          hit_a, hit_b, tick, run, cnt_we;

  always_comb begin
    run    = run_en && !(cfg.stop_en && halt_i);
    cnt_we = bus_wr_i && (gpt_addr_e'(bus_addr_i) == A_COUNT);
  end

  gpt_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr_i),
    .rd     (bus_rd_i),
    .addr   (bus_addr_i),
    .wdata  (bus_wdata_i),
    .cnt    (cnt),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .cmp_a  (cmp_a),
    .cmp_b  (cmp_b),
    .cfg    (cfg),
    .run_en (run_en),
    .locked (locked),
    .ev_b   (ev_b),
    .clr_b  (clr_b),
    .rdata  (bus_rdata_o),
    .irq    (irq_o)
  );

  gpt_prescaler #(.PSW(PS_W)) u_pre (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .src_fast    (cfg.src_fast),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .prescale    (cfg.prescale),
    .tick        (tick)
  );

  gpt_counter #(.W(DW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cnt_we (cnt_we),
    .wdata  (bus_wdata_i),
    .cmp_a  (cmp_a),
    .cmp_b  (cmp_b),
    .mode   (cfg.mode),
    .cnt    (cnt),
    .hit_a  (hit_a),
    .hit_b  (hit_b)
  );

endmodule

// File: rtl/gpt_channel_chk.sv
module gpt_channel_chk
  import gpt_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          locked,
  input gpt_cfg_t      cfg,
  input logic          run_en,
  input logic          halt_i,
  input logic          irq_o,
  input logic          ev_b,
  input logic          clr_b,
  input logic          hit_b,
  input logic          cnt_we,
  input logic [DW-1:0] cnt
);

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg));

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  a_r8_event_sticky: assert property (@(posedge clk) disable iff (rst)
    (ev_b && !clr_b) |=> ev_b);

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    hit_b |=> ev_b);

  a_r9_irq_needs_event: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ev_b && cfg.mode == M_GEIRQ));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (hit_b && !cnt_we) |=> (cnt == '0));

  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !cnt_we) |=> $stable(cnt));

  a_r11_freeze_on_halt: assert property (@(posedge clk) disable iff (rst)
    (cfg.stop_en && halt_i && !cnt_we) |=> $stable(cnt));

endmodule

bind gpt_channel gpt_channel_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .locked (locked),
  .cfg    (cfg),
  .run_en (run_en),
  .halt_i (halt_i),
  .irq_o  (irq_o),
  .ev_b   (ev_b),
  .clr_b  (clr_b),
  .hit_b  (hit_b),
  .cnt_we (cnt_we),
  .cnt    (cnt)
);

// File: tb/tb_gpt_channel.sv
module tb_gpt_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_tick_i = 1'b1;
  logic        slow_tick_i = 1'b0;
  logic        halt_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [1:0]  bus_addr_i = 2'd0;
  logic [15:0] bus_wdata_i = 16'd0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [1:0] AD_CMPA = 2'd0, AD_CMPB = 2'd1, AD_CNT = 2'd2, AD_SETUP = 2'd3;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) slow_tick_i <= ((cyc % 4) == 0);

  gpt_channel dut (
    .clk(clk), .rst(rst), .fast_tick_i(fast_tick_i), .slow_tick_i(slow_tick_i),
    .halt_i(halt_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; halt_i = 1'b0; bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic wait_irq(output int stamp);
    int n = 0;
    while (!irq_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    stamp = cyc;
    check(irq_o == 1'b1, "R9 irq timeout", irq_o, 1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    bus_read(AD_SETUP, d); check(d == 16'h0, "R1 setup", d, 0);
    bus_read(AD_CNT, d);   check(d == 16'h0, "R1 count", d, 0);
    bus_read(AD_CMPB, d);  check(d == 16'h0, "R1 cmpb", d, 0);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    do_reset();
    bus_write(AD_SETUP, 16'h07F2);
    bus_read(AD_SETUP, d);
    check(d == 16'h1312, "R2/R3 first setup and unused zero", d, 16'h1312);
    bus_write(AD_SETUP, 16'h8B05);
    bus_read(AD_SETUP, d);
    check((d & 16'h9FFF) == 16'h9312, "R3 cfg kept, run set", d & 16'h9FFF, 16'h9312);
    bus_write(AD_SETUP, 16'h0000);
    bus_read(AD_SETUP, d);
    check((d & 16'h9FFF) == 16'h1312, "R3 run cleared", d & 16'h9FFF, 16'h1312);
    bus_write(AD_CMPA, 16'h1234);
    bus_read(AD_CMPA, d);
    check(d == 16'h1234, "R2 cmpa address", d, 16'h1234);
  endtask

  task automatic t_period_fast();
    int t1, t2;
    do_reset();
    bus_write(AD_CMPB, 16'd4);
    bus_write(AD_SETUP, 16'h8312);
    wait_irq(t1);
    repeat (5) @(negedge clk);
    check(irq_o == 1'b1, "R9 irq held", irq_o, 1);
    bus_write(AD_SETUP, 16'hC000);
    check(irq_o == 1'b0, "R8/R9 clear drops irq", irq_o, 0);
    wait_irq(t2);
    check((t2 - t1) == 20, "R4/R6 period prescale 4 cmp 4", t2 - t1, 20);
  endtask

  task automatic t_period_slow();
    int t1, t2;
    do_reset();
    bus_write(AD_CMPB, 16'd3);
    bus_write(AD_SETUP, 16'h8300);
    wait_irq(t1);
    bus_write(AD_SETUP, 16'hC000);
    wait_irq(t2);
    check((t2 - t1) == 16, "R5 slow source period", t2 - t1, 16);
  endtask

  task automatic t_ge_no_irq_and_cmpa();
    logic [15:0] d;
    do_reset();
    bus_write(AD_CMPA, 16'd2);
    bus_write(AD_CMPB, 16'd8);
    bus_write(AD_SETUP, 16'h8210);
    repeat (30) @(negedge clk);
    check(irq_o == 1'b0, "R9 mode 10 no irq", irq_o, 0);
    bus_write(AD_SETUP, 16'h0000);
    bus_read(AD_SETUP, d);
    check(d[14] == 1'b1, "R6 mode 10 event", d[14], 1);
    check(d[13] == 1'b1, "R7 compare A event", d[13], 1);
    bus_write(AD_SETUP, 16'h2000);
    bus_read(AD_SETUP, d);
    check(d[13] == 1'b0, "R8 clear A", d[13], 0);
    check(d[14] == 1'b1, "R8 B untouched", d[14], 1);
  endtask

  task automatic t_count_write_ge();
    logic [15:0] d;
    do_reset();
    bus_write(AD_CMPB, 16'd5);
    bus_write(AD_SETUP, 16'h0310);
    bus_write(AD_CNT, 16'd10);
    repeat (5) @(negedge clk);
    bus_read(AD_CNT, d);
    check(d == 16'd10, "R10 load and hold", d, 10);
    bus_write(AD_SETUP, 16'h8000);
    repeat (2) @(negedge clk);
    bus_write(AD_SETUP, 16'h0000);
    bus_read(AD_CNT, d);
    check(d < 16'd5, "R6 GE wrap from above", d, 0);
    bus_read(AD_SETUP, d);
    check(d[14] == 1'b1, "R6 GE event", d[14], 1);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    do_reset();
    bus_write(AD_SETUP, 16'h8310);
    repeat (5) @(negedge clk);
    bus_write(AD_SETUP, 16'hC000);
    check(irq_o == 1'b1, "R8 set beats clear irq", irq_o, 1);
    bus_read(AD_SETUP, d);
    check(d[14] == 1'b1, "R8 set beats clear flag", d[14], 1);
  endtask

  task automatic t_halt();
    logic [15:0] a, b, c;
    do_reset();
    bus_write(AD_SETUP, 16'h8810);
    repeat (10) @(negedge clk);
    halt_i = 1'b1;
    @(negedge clk);
    bus_read(AD_CNT, a);
    repeat (10) @(negedge clk);
    bus_read(AD_CNT, b);
    check(a == b, "R11 frozen", b, a);
    halt_i = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(AD_CNT, c);
    check(c != b, "R11 resumes", c, b + 1);
    bus_read(AD_SETUP, a);
    check(a[14] == 1'b0 && irq_o == 1'b0, "R6 mode 00 no event", a[14], 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock();
    t_period_fast();
    t_period_slow();
    t_ge_no_irq_and_cmpa();
    t_count_write_ge();
    t_collision();
    t_halt();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule